// File: doc/BRIEF.md
# Dual-Register Serial-to-Parallel Latch

This block converts a serial bit stream into an 8-bit parallel word. The bits are first collected in a shift stage. A separate strobe then copies the whole shift stage into a holding register, and the holding register drives the parallel outputs. Because the two stages are clocked separately, a new word can be assembled in the background. It is then presented on all eight outputs in one step, with no intermediate patterns visible.

Everything runs on one system clock. The shift and store events arrive as single-cycle strobes. The clear input is active low. It passes through a two-flop synchroniser before it acts, and it empties only the shift stage. An active-low output enable turns on a per-bit drive-enable bus, which a wrapper can use to tri-state the outputs. A cascade output carries the last shift stage so that several blocks can be chained.

Top module: `ser_par_latch`

## Requirements
- R1: While `rst_n` is low, both the shift stage and the holding register are cleared. After reset, `par_out` reads 0x00 and `casc_out` reads 0.
- R2: On a clock edge where `shift_stb` is high and clear is not in effect, `ser_in` enters stage 0 and each stage n moves to stage n+1. Bit 0 of `par_out` therefore shows the most recently shifted bit after a store.
- R3: On a clock edge where `shift_stb` is low and clear is not in effect, the shift stage keeps its value.
- R4: On a clock edge where `store_stb` is high, the holding register loads all eight shift stages in parallel: `par_out[i]` becomes stage i. With no store strobe, the holding register keeps its value.
- R5: When `shift_stb` and `store_stb` are high on the same edge, the holding register captures the shift stage as it was before that shift.
- R6: `casc_out` always equals stage 7 of the shift stage, never the holding register.
- R7: Clear takes effect two clock edges after `clr_n` goes low, and it ends two edges after `clr_n` returns high. While clear is in effect, every shift stage is forced to zero, even if `shift_stb` is high. The holding register is not touched.
- R8: A `store_stb` on an edge where clear is in effect loads 0x00 into the holding register, even if the shift stage held data just before.
- R9: `par_oe` is 0xFF while `oe_n` is low and 0x00 while `oe_n` is high. `oe_n` has no effect on either register or on `casc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| shift_stb | input | 1 | Single-cycle shift strobe |
| store_stb | input | 1 | Single-cycle store strobe |
| clr_n | input | 1 | Active-low clear of the shift stage (synchronised inside) |
| oe_n | input | 1 | Active-low output enable |
| par_out | output | 8 | Holding register contents |
| par_oe | output | 8 | Per-bit drive enable for `par_out` |
| casc_out | output | 1 | Cascade output, stage 7 of the shift stage |

## Verification
The hardest case to reach is a store strobe on the first edge where clear takes effect. That is the only edge on which the shift stage still holds data, so it is the only edge that can tell "load zeros" apart from "load the shift stage". The bench first fills the shift stage with a known non-zero word. It then drops `clr_n` and counts the two synchroniser edges, so that the store strobe lands on exactly that edge. A second case checks that clear overrides shifting. The bench keeps `shift_stb` high with `ser_in` at 1 for the whole clear, then stores the shift stage after the clear is released and expects 0x00.

// File: rtl/ser_par_latch.sv
module ser_par_latch #(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             store_stb,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic [WIDTH-1:0] par_oe,
  output logic             casc_out
);

  logic [SYNC_DEPTH-1:0] clr_sync;
  logic                  clear_act;
  logic [WIDTH-1:0]      sr;
  logic [WIDTH-1:0]      hr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_sync <= '0;
    else        clr_sync <= {clr_sync[SYNC_DEPTH-2:0], clr_n};
  end

  assign clear_act = ~clr_sync[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (clear_act) sr <= '0;
    else if (shift_stb) sr <= {sr[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hr <= '0;
    else if (store_stb) hr <= clear_act ? '0 : sr;
  end

  assign par_out  = hr;
  assign par_oe   = {WIDTH{~oe_n}};
  assign casc_out = sr[WIDTH-1];

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && !clear_act) |=> sr == {$past(sr[WIDTH-2:0]), $past(ser_in)});

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_stb && !clear_act) |=> $stable(sr));

  // R5
  store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && !clear_act) |=> hr == $past(sr));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_act |=> sr == '0);

  // R7
  clear_keep_hr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_act && !store_stb) |=> $stable(hr));

  // R8
  clear_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_act && store_stb) |=> par_out == '0);

endmodule

// File: tb/test_ser_par_latch.sv
module test_ser_par_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, ser_in, shift_stb, store_stb, clr_n, oe_n;
  logic [7:0] par_out, par_oe;
  logic casc_out;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_par_latch i_ser_par_latch (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
    .store_stb(store_stb), .clr_n(clr_n), .oe_n(oe_n),
    .par_out(par_out), .par_oe(par_oe), .casc_out(casc_out)
  );

  // {ser, shift, store, oe_n, exp_par[7:0], exp_oe[7:0], exp_casc}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {4'b1100, 8'h00, 8'hFF, 1'b0},
    {4'b0100, 8'h00, 8'hFF, 1'b0},
    {4'b1100, 8'h00, 8'hFF, 1'b0},
    {4'b0100, 8'h00, 8'hFF, 1'b0},
    {4'b0100, 8'h00, 8'hFF, 1'b0},
    {4'b1100, 8'h00, 8'hFF, 1'b0},
    {4'b0100, 8'h00, 8'hFF, 1'b0},
    {4'b1100, 8'h00, 8'hFF, 1'b1},
    {4'b1110, 8'hA5, 8'hFF, 1'b0},
    {4'b0010, 8'h4B, 8'hFF, 1'b0},
    {4'b0001, 8'h4B, 8'h00, 1'b0},
    {4'b1101, 8'h4B, 8'h00, 1'b1},
    {4'b0010, 8'h97, 8'hFF, 1'b1}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; shift_stb = 1'b0; store_stb = 1'b0;
    clr_n = 1'b1; oe_n = 1'b0;
    repeat (3) step();
    // R1 reset state
    check("R1 par_out", par_out, 8'h00);
    check("R1 casc_out", {7'b0, casc_out}, 8'h00);
    check("R9 par_oe", par_oe, 8'hFF);
    rst_n = 1'b1;
    repeat (3) step();

    // R2 R3 R4 R5 R6 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      {ser_in, shift_stb, store_stb, oe_n} = VEC[i][20:17];
      step();
      check($sformatf("R2/R4/R5 par_out v%0d", i), par_out, VEC[i][16:9]);
      check($sformatf("R9 par_oe v%0d", i), par_oe, VEC[i][8:1]);
      check($sformatf("R6 casc_out v%0d", i), {7'b0, casc_out}, {7'b0, VEC[i][0]});
    end
    shift_stb = 1'b0; store_stb = 1'b0; oe_n = 1'b0;
    step();
    // R3 idle holds stage 7 (sr = 97)
    check("R3 casc_out idle", {7'b0, casc_out}, 8'h01);

    // R7 clear overrides shift, holding register untouched
    clr_n = 1'b0; shift_stb = 1'b1; ser_in = 1'b1;
    repeat (6) step();
    check("R7 casc_out during clear", {7'b0, casc_out}, 8'h00);
    check("R7 par_out kept", par_out, 8'h97);
    shift_stb = 1'b0; clr_n = 1'b1;
    repeat (3) step();
    store_stb = 1'b1;
    step();
    store_stb = 1'b0;
    check("R7 shift stage zero", par_out, 8'h00);

    // refill shift stage with 07
    shift_stb = 1'b1; ser_in = 1'b1;
    repeat (3) step();
    shift_stb = 1'b0;
    step();

    // R8 store on first edge clear takes effect
    clr_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    store_stb = 1'b1;
    step();
    store_stb = 1'b0;
    check("R8 store during clear", par_out, 8'h00);
    clr_n = 1'b1;
    repeat (3) step();

    // R9 oe_n high then low with no effect on contents
    oe_n = 1'b1;
    step();
    check("R9 par_oe off", par_oe, 8'h00);
    oe_n = 1'b0;
    step();
    check("R9 par_oe on", par_oe, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule